// File: doc/BRIEF.md
# In-Order Group Issue Gate

This block sits between decode and execute in a machine that issues up to four instructions per cycle. It holds one naturally aligned group of decoded instructions. Each cycle it decides which of the still-pending instructions go out, always in program order. Each slot describes one instruction: a valid bit, one destination register, two source registers, and a use flag for each register.

Within the held group, every slot is compared against every earlier pending slot. The comparisons look for read-after-write hazards (a source matching an earlier destination), write-after-write hazards (two equal destinations) and write-after-read hazards (a destination matching an earlier source). Issue stops at the first slot that is blocked. The blocked slot and everything behind it stay in place and retry on the next cycle, while the slots that did issue become empty.

A new group is only taken once every slot of the current group has issued. Nothing is shifted or merged across groups. An external busy input stands in for all reasons outside the group, and a flush input discards the held group.

Top module: `grp_issue_gate`

## Requirements
- R1: After reset, `grp_ready` is 1 and `issue_mask` is 0.
- R2: A group is taken at a clock edge where `grp_valid` and `grp_ready` are both 1 and `flush` is 0. Slot i becomes pending only if `grp_slot_vld[i]` is 1 and i is at or above `grp_entry`. If no slot becomes pending, `grp_ready` stays 1.
- R3: `issue_mask` bit i is 1 when slot i issues in the current cycle. The issued slots are all pending slots that lie below the lowest blocked pending slot. Issue is decided from the held group, so it is visible in the cycle after the group is taken.
- R4: A pending slot is blocked when one of its used sources equals the used destination of an earlier pending slot (read after write).
- R5: A pending slot is blocked when its used destination equals the used destination of an earlier pending slot (write after write).
- R6: A pending slot is blocked when its used destination equals a used source of an earlier pending slot (write after read).
- R7: Register 0 never causes a hazard, and neither does a register whose use flag is 0.
- R8: Slots that issue become empty at the next edge. Blocked slots keep their contents and are evaluated again in the next cycle.
- R9: While `busy` is 1, `issue_mask` is 0 and the group is kept.
- R10: While `flush` is 1, `issue_mask` is 0. At the next edge every slot is emptied, and a group offered in the same cycle is discarded.
- R11: `issue_cnt` equals the number of ones in `issue_mask`.
- R12: `grp_ready` is 1 exactly when no slot is pending. A group offered while slots are still pending is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_valid | input | 1 | A new group is offered |
| grp_ready | output | 1 | No slot pending; a group can be taken |
| grp_entry | input | 2 | Index of the first live slot in the offered group |
| grp_slot_vld | input | 4 | Per-slot valid bits |
| grp_dst | input | 20 | Destination register per slot, slot i at bits [5i+4:5i] |
| grp_dst_use | input | 4 | Destination use flags |
| grp_srca | input | 20 | First source per slot, same packing |
| grp_srca_use | input | 4 | First source use flags |
| grp_srcb | input | 20 | Second source per slot, same packing |
| grp_srcb_use | input | 4 | Second source use flags |
| busy | input | 1 | Hold all issue this cycle |
| flush | input | 1 | Discard the held group |
| issue_mask | output | 4 | Slots issuing this cycle |
| issue_cnt | output | 3 | Number of slots issuing this cycle |

## Verification
A group offered before edge c+1 appears in the held state after that edge. Its first issue mask is therefore due during cycle c+1, and each retry after that is due exactly one cycle later. `busy` and `flush` act combinationally on the mask in the cycle in which they are driven, while their effect on `grp_ready` shows one edge later. The bench keeps to this timing: the driver drives inputs on the falling edge and tags every expected mask and ready value with its absolute cycle number. The monitor pops each entry in that cycle, shortly after the falling edge, once the combinational outputs have settled.

// File: rtl/grp_issue_gate.sv
module grp_issue_gate #(
  parameter int LANES = 4,
  parameter int REG_W = 5,
  localparam int PTR_W = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   grp_valid,
  output logic                   grp_ready,
  input  logic [PTR_W-1:0]       grp_entry,
  input  logic [LANES-1:0]       grp_slot_vld,
  input  logic [LANES*REG_W-1:0] grp_dst,
  input  logic [LANES-1:0]       grp_dst_use,
  input  logic [LANES*REG_W-1:0] grp_srca,
  input  logic [LANES-1:0]       grp_srca_use,
  input  logic [LANES*REG_W-1:0] grp_srcb,
  input  logic [LANES-1:0]       grp_srcb_use,
  input  logic                   busy,
  input  logic                   flush,
  output logic [LANES-1:0]       issue_mask,
  output logic [CNT_W-1:0]       issue_cnt
);

  logic [LANES-1:0] pend;
  logic [LANES-1:0] dst_u, sa_u, sb_u;
  logic [REG_W-1:0] dst_q [LANES];
  logic [REG_W-1:0] sa_q  [LANES];
  logic [REG_W-1:0] sb_q  [LANES];

  logic [LANES-1:0] wr, rda, rdb, hz, stop;
  logic take;

  assign grp_ready = ~|pend;
  assign take      = grp_valid & grp_ready & ~flush;

  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      wr[i]  = dst_u[i] & (|dst_q[i]);
      rda[i] = sa_u[i]  & (|sa_q[i]);
      rdb[i] = sb_u[i]  & (|sb_q[i]);
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      hz[k] = 1'b0;
      for (int j = 0; j < k; j++) begin
        hz[k] = hz[k] | (pend[j] & (
                  (wr[j] & rda[k] & (sa_q[k] == dst_q[j])) |
                  (wr[j] & rdb[k] & (sb_q[k] == dst_q[j])) |
                  (wr[j] & wr[k]  & (dst_q[k] == dst_q[j])) |
                  (wr[k] & rda[j] & (sa_q[j] == dst_q[k])) |
                  (wr[k] & rdb[j] & (sb_q[j] == dst_q[k]))));
      end
    end
  end

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      if (k == 0) stop[k] = pend[k] & (busy | flush | hz[k]);
      else        stop[k] = stop[k-1] | (pend[k] & (busy | flush | hz[k]));
    end
  end

  assign issue_mask = pend & ~stop;

  always_comb begin
    issue_cnt = '0;
    for (int i = 0; i < LANES; i++) issue_cnt = issue_cnt + CNT_W'(issue_mask[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      pend <= '0;
    end else if (take) begin
      for (int i = 0; i < LANES; i++)
        pend[i] <= grp_slot_vld[i] & (PTR_W'(i) >= grp_entry);
    end else begin
      pend <= pend & ~issue_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      dst_u <= grp_dst_use;
      sa_u  <= grp_srca_use;
      sb_u  <= grp_srcb_use;
      for (int i = 0; i < LANES; i++) begin
        dst_q[i] <= grp_dst[i*REG_W +: REG_W];
        sa_q[i]  <= grp_srca[i*REG_W +: REG_W];
        sb_q[i]  <= grp_srcb[i*REG_W +: REG_W];
      end
    end
  end

endmodule

// File: rtl/grp_issue_gate_chk.sv
module grp_issue_gate_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             flush,
  input logic             grp_ready,
  input logic [LANES-1:0] issue_mask,
  input logic [LANES-1:0] pend
);

  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> issue_mask == '0);

  assert_flush_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> grp_ready);

  assert_only_pending_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_mask & ~pend) == '0);

  assert_progress_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_ready && !busy && !flush) |-> issue_mask != '0);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    grp_ready |-> issue_mask == '0);

  assert_drain_first_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && pend != '0 && issue_mask != pend) |=> !grp_ready);

endmodule

bind grp_issue_gate grp_issue_gate_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .flush(flush),
  .grp_ready(grp_ready), .issue_mask(issue_mask), .pend(pend)
);

// File: tb/grp_issue_gate_bench.sv
module grp_issue_gate_bench;
  localparam int L = 4;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, grp_valid, grp_ready, busy, flush;
  logic [1:0] grp_entry;
  logic [L-1:0] grp_slot_vld, grp_dst_use, grp_srca_use, grp_srcb_use, issue_mask;
  logic [L*RW-1:0] grp_dst, grp_srca, grp_srcb;
  logic [2:0] issue_cnt;

  grp_issue_gate u_grp_issue_gate (
    .clk(clk), .rst_n(rst_n), .grp_valid(grp_valid), .grp_ready(grp_ready),
    .grp_entry(grp_entry), .grp_slot_vld(grp_slot_vld),
    .grp_dst(grp_dst), .grp_dst_use(grp_dst_use),
    .grp_srca(grp_srca), .grp_srca_use(grp_srca_use),
    .grp_srcb(grp_srcb), .grp_srcb_use(grp_srcb_use),
    .busy(busy), .flush(flush), .issue_mask(issue_mask), .issue_cnt(issue_cnt)
  );

  typedef struct { int cyc; logic [3:0] mask; logic rdy; int req; } exp_t;
  exp_t q[$];
  exp_t cur;
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(int req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL R%0d %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      cur = q.pop_front();
      chk(cur.req, "issue_mask", int'(issue_mask), int'(cur.mask));
      chk(11, "issue_cnt", int'(issue_cnt), $countones(cur.mask));   // R11
      chk(cur.req, "grp_ready", int'(grp_ready), int'(cur.rdy));
    end
  end

  task automatic expect_at(int d, logic [3:0] m, logic r, int req);
    exp_t e;
    e.cyc = cyc + d; e.mask = m; e.rdy = r; e.req = req;
    q.push_back(e);
  endtask

  task automatic slot(int k, bit v, int d, bit du, int a, bit au, int b, bit bu);
    grp_slot_vld[k] = v;
    grp_dst[k*RW +: RW] = RW'(d);   grp_dst_use[k]  = du;
    grp_srca[k*RW +: RW] = RW'(a);  grp_srca_use[k] = au;
    grp_srcb[k*RW +: RW] = RW'(b);  grp_srcb_use[k] = bu;
  endtask

  task automatic base_group();
    grp_entry = 2'd0;
    slot(0, 1, 1, 1, 10, 1, 11, 1);
    slot(1, 1, 2, 1, 12, 1, 13, 1);
    slot(2, 1, 3, 1, 14, 1, 15, 1);
    slot(3, 1, 4, 1, 16, 1, 17, 1);
  endtask

  task automatic chain_group();
    grp_entry = 2'd0;
    slot(0, 1, 1, 1, 10, 1, 11, 1);
    slot(1, 1, 2, 1, 1, 1, 11, 1);
    slot(2, 1, 3, 1, 20, 1, 2, 1);
    slot(3, 1, 4, 1, 3, 1, 21, 1);
  endtask

  task automatic offer_pulse();
    grp_valid = 1'b1;
    @(negedge clk);
    grp_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; grp_valid = 1'b0; busy = 1'b0; flush = 1'b0;
    grp_entry = '0; grp_slot_vld = '0; grp_dst = '0; grp_dst_use = '0;
    grp_srca = '0; grp_srca_use = '0; grp_srcb = '0; grp_srcb_use = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(1, "reset grp_ready", int'(grp_ready), 1);   // R1
    chk(1, "reset issue_mask", int'(issue_mask), 0); // R1
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    // R3: independent group issues whole
    base_group();
    expect_at(1, 4'b1111, 1'b0, 3); expect_at(2, 4'b0000, 1'b1, 12);
    offer_pulse(); settle();

    // R4: slot1 reads slot0 destination
    base_group(); slot(1, 1, 2, 1, 1, 1, 13, 1);
    expect_at(1, 4'b0001, 1'b0, 4); expect_at(2, 4'b1110, 1'b0, 8); expect_at(3, 4'b0000, 1'b1, 12);
    offer_pulse(); settle();

    // R5: slot2 writes slot0 destination
    base_group(); slot(2, 1, 1, 1, 14, 1, 15, 1);
    expect_at(1, 4'b0011, 1'b0, 5); expect_at(2, 4'b1100, 1'b0, 8); expect_at(3, 4'b0000, 1'b1, 12);
    offer_pulse(); settle();

    // R6: slot3 writes a register slot1 reads
    base_group(); slot(3, 1, 12, 1, 16, 1, 17, 1);
    expect_at(1, 4'b0111, 1'b0, 6); expect_at(2, 4'b1000, 1'b0, 8); expect_at(3, 4'b0000, 1'b1, 12);
    offer_pulse(); settle();

    // R7: register 0 and unused fields never conflict
    grp_entry = 2'd0;
    slot(0, 1, 0, 1, 10, 1, 11, 1);
    slot(1, 1, 2, 1, 0, 1, 0, 1);
    slot(2, 1, 0, 1, 14, 1, 15, 1);
    slot(3, 1, 5, 1, 2, 0, 3, 0);
    expect_at(1, 4'b1111, 1'b0, 7); expect_at(2, 4'b0000, 1'b1, 7);
    offer_pulse(); settle();

    // R8: dependence chain retries one slot per cycle
    chain_group();
    expect_at(1, 4'b0001, 1'b0, 8); expect_at(2, 4'b0010, 1'b0, 8);
    expect_at(3, 4'b0100, 1'b0, 8); expect_at(4, 4'b1000, 1'b0, 8);
    expect_at(5, 4'b0000, 1'b1, 8);
    offer_pulse(); settle();

    // R2: entry at slot 2 drops slot0, so slot3 no longer conflicts
    base_group(); slot(3, 1, 4, 1, 1, 1, 17, 1); grp_entry = 2'd2;
    expect_at(1, 4'b1100, 1'b0, 2); expect_at(2, 4'b0000, 1'b1, 2);
    offer_pulse(); settle();

    // R2: entry at slot 1 with slot2 invalid
    base_group(); grp_entry = 2'd1; slot(2, 0, 3, 1, 14, 1, 15, 1);
    expect_at(1, 4'b1010, 1'b0, 2); expect_at(2, 4'b0000, 1'b1, 2);
    offer_pulse(); settle();

    // R2: no live slot at or above entry keeps the block ready
    base_group(); grp_entry = 2'd3; slot(3, 0, 4, 1, 16, 1, 17, 1);
    expect_at(1, 4'b0000, 1'b1, 2);
    offer_pulse(); settle();

    // R9: busy holds the group for two cycles
    base_group(); busy = 1'b1;
    expect_at(1, 4'b0000, 1'b0, 9); expect_at(2, 4'b0000, 1'b0, 9);
    expect_at(3, 4'b1111, 1'b0, 9); expect_at(4, 4'b0000, 1'b1, 9);
    offer_pulse();
    @(negedge clk);
    @(negedge clk); busy = 1'b0;
    settle();

    // R12: a second group offered while draining is ignored
    base_group(); slot(1, 1, 2, 1, 1, 1, 13, 1);
    expect_at(1, 4'b0001, 1'b0, 12); expect_at(2, 4'b1110, 1'b0, 12);
    expect_at(3, 4'b0000, 1'b1, 12); expect_at(4, 4'b0000, 1'b1, 12);
    grp_valid = 1'b1;
    @(negedge clk); base_group();
    @(negedge clk);
    @(negedge clk); grp_valid = 1'b0;
    settle();

    // R10: flush in the first held cycle discards the chain
    chain_group();
    expect_at(1, 4'b0000, 1'b0, 10); expect_at(2, 4'b0000, 1'b1, 10); expect_at(3, 4'b0000, 1'b1, 10);
    grp_valid = 1'b1;
    @(negedge clk); grp_valid = 1'b0; flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    settle();

    // R10: group offered together with flush is dropped
    base_group();
    expect_at(1, 4'b0000, 1'b1, 10); expect_at(2, 4'b0000, 1'b1, 10);
    grp_valid = 1'b1; flush = 1'b1;
    @(negedge clk); grp_valid = 1'b0; flush = 1'b0;
    settle();

    // R3: normal operation after flushes
    base_group();
    expect_at(1, 4'b1111, 1'b0, 3); expect_at(2, 4'b0000, 1'b1, 3);
    offer_pulse(); settle();

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule